// File: doc/BRIEF.md
# CRC Accumulate Execute Unit

This unit sits in the execute stage of a processor and carries out a CRC accumulate instruction. It receives the 32-bit instruction word, the two operand values already read from the register file, a feature-enable bit and a 64-bit-mode bit. It decodes the instruction and checks that it is legal. A legal instruction folds 1, 2, 4 or 8 message bytes into a running 32-bit CRC. The instruction selects one of two reflected polynomials. The unit returns the sign-extended result together with a write-enable and the destination index.

Work is byte-serial, with one message byte per clock. A valid/ready handshake admits one instruction at a time, and ready stays low while a fold is in progress. An illegal instruction is refused in the cycle it is offered, through a reserved-instruction flag, and no write-back follows it. The register file, hazard handling and exception vectoring belong to the surrounding pipeline.

Top module: `crc_accum_exu`

## Requirements
- R1: An instruction is recognised only when bits[31:26]=6'b011111, bits[15:11]=5'b00000 and bits[5:0]=6'b001111. The message register index is bits[25:21] and appears on `rs_idx`. The CRC/destination index is bits[20:16]. The polynomial code is bits[10:8] and the size code is bits[7:6]. Any other word is reserved.
- R2: While `feat_en` is 0, every offered instruction is reserved.
- R3: Polynomial code 0 selects the reflected CRC-32 polynomial 0xEDB88320, and code 1 selects the reflected CRC-32C polynomial 0x82F63B78. Codes 2 to 7 are reserved.
- R4: Size code 3 (8 bytes) is reserved unless `mode64` is 1.
- R5: A legal instruction folds 1<<sz bytes of `rs_val`, least-significant byte first. Each byte is XORed into the low byte of the CRC, followed by eight LSB-first shift/conditional-XOR steps. The low 32 bits of the CRC operand are used as the starting value, with no inversion at input or output. Bytes of `rs_val` above the selected count have no effect.
- R6: The 32-bit result is sign-extended to 64 bits on `out_data`.
- R7: `out_rd` equals the bits[20:16] field. `out_wen` is 1 in the done cycle unless that index is 0. For index 0 the operation still completes with `out_done`=1 and `out_wen`=0.
- R8: A reserved instruction raises `out_rsvd` in its accept cycle only. No `out_done` or write follows it, and `in_ready` stays 1.
- R9: A legal instruction accepted at clock edge k produces `out_done`=1 for exactly one cycle after edge k+(1<<sz). `in_ready` is 0 from edge k+1 until that result appears.
- R10: Inputs presented while `in_ready` is 0 are not taken and do not change the result in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands offered |
| in_ready | output | 1 | Unit idle and able to accept |
| insn | input | 32 | Instruction word |
| rs_val | input | 64 | Message operand |
| rt_lo | input | 32 | Low word of the running-CRC operand |
| feat_en | input | 1 | CRC instruction feature enabled |
| mode64 | input | 1 | 64-bit operation enabled |
| rs_idx | output | 5 | Message register index decoded from `insn` |
| out_rsvd | output | 1 | Reserved-instruction exception, in the accept cycle |
| out_done | output | 1 | Result completes this cycle |
| out_wen | output | 1 | Write `out_data` to register `out_rd` |
| out_rd | output | 5 | Destination register index |
| out_data | output | 64 | Sign-extended CRC result |

## Verification
The assertions assume that `in_valid` is driven to a known level from reset onward. They also assume that a reserved offer is not repeated in the cycle right after it, so a completion there can only come from an earlier legal accept. The bench offers each instruction for exactly one accepted cycle and waits for the completion or the refusal before it offers the next. In the busy-input test it holds junk on the inputs only while `in_ready` is 0 and clears `in_valid` before the unit becomes idle.

// File: rtl/crc_accum_pkg.sv
package crc_accum_pkg;

    localparam int CRC_W    = 32;
    localparam int BYTE_W   = 8;
    localparam int IDX_W    = 5;
    localparam int INSN_W   = 32;

    localparam logic [5:0] MAJOR_OP = 6'b011111;
    localparam logic [5:0] MINOR_OP = 6'b001111;

    localparam logic [CRC_W-1:0] POLY_STD  = 32'hEDB88320;
    localparam logic [CRC_W-1:0] POLY_CAST = 32'h82F63B78;

    typedef enum logic {
        POLY_SEL_STD  = 1'b0,
        POLY_SEL_CAST = 1'b1
    } poly_sel_e;

    typedef struct packed {
        logic             illegal;
        poly_sel_e        poly;
        logic [1:0]       size_log2;
        logic [IDX_W-1:0] src_idx;
        logic [IDX_W-1:0] acc_idx;
    } dec_t;

endpackage

// File: rtl/crc_insn_decode.sv
module crc_insn_decode
    import crc_accum_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    input  logic              feat_en,
    input  logic              mode64,
    output dec_t              dec
);

    logic       pattern_hit;
    logic [2:0] poly_code;
    logic [1:0] size_code;

    always_comb begin
        pattern_hit = (insn[31:26] == MAJOR_OP) &&
                      (insn[15:11] == 5'b00000) &&
                      (insn[5:0]   == MINOR_OP);
        poly_code   = insn[10:8];
        size_code   = insn[7:6];

        dec.src_idx   = insn[25:21];
        dec.acc_idx   = insn[20:16];
        dec.size_log2 = size_code;
        dec.poly      = poly_sel_e'(poly_code[0]);
        dec.illegal   = !pattern_hit ||
                        !feat_en ||
                        (poly_code[2:1] != 2'b00) ||
                        ((size_code == 2'd3) && !mode64);
    end

    // R2
    feat_off_chk: assert final (feat_en || dec.illegal);
    // R3
    poly_code_chk: assert final ((insn[10:9] == 2'b00) || dec.illegal);

endmodule

// File: rtl/crc_byte_fold.sv
module crc_byte_fold
    import crc_accum_pkg::*;
#(
    parameter int STEPS = BYTE_W
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [BYTE_W-1:0] msg_byte,
    input  poly_sel_e         poly,
    output logic [CRC_W-1:0]  crc_out
);

    logic [CRC_W-1:0] poly_word;
    logic [CRC_W-1:0] chain [STEPS+1];

    always_comb begin
        poly_word = (poly == POLY_SEL_CAST) ? POLY_CAST : POLY_STD;
        chain[0]  = crc_in ^ {{(CRC_W-BYTE_W){1'b0}}, msg_byte};
    end

    for (genvar s = 0; s < STEPS; s++) begin : g_step
        always_comb begin
            chain[s+1] = (chain[s] >> 1) ^ (chain[s][0] ? poly_word : '0);
        end
    end

    assign crc_out = chain[STEPS];

endmodule

// File: rtl/crc_fold_seq.sv
module crc_fold_seq
    import crc_accum_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  dec_t             dec,
    input  logic [XLEN-1:0]  msg_in,
    input  logic [CRC_W-1:0] crc_init,
    output logic             busy,
    output logic [CRC_W-1:0] fold_crc,
    output logic [BYTE_W-1:0] fold_byte,
    output poly_sel_e        fold_poly,
    input  logic [CRC_W-1:0] fold_res,
    output logic             done,
    output logic             wen,
    output logic [IDX_W-1:0] rd,
    output logic [XLEN-1:0]  data
);

    localparam int MAX_BYTES = XLEN / BYTE_W;
    localparam int CNT_W     = $clog2(MAX_BYTES + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] left;
        logic [CRC_W-1:0] crc;
        logic [XLEN-1:0]  msg;
        poly_sel_e        poly;
        logic [IDX_W-1:0] rd;
        logic             done;
        logic             wen;
        logic [XLEN-1:0]  data;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.wen  = 1'b0;
        if (s_q.busy) begin
            s_d.crc  = fold_res;
            s_d.msg  = s_q.msg >> BYTE_W;
            s_d.left = s_q.left - 1'b1;
            if (s_q.left == CNT_W'(1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
                s_d.wen  = (s_q.rd != '0);
                s_d.data = {{(XLEN-CRC_W){fold_res[CRC_W-1]}}, fold_res};
            end
        end else if (start) begin
            s_d.busy = 1'b1;
            s_d.left = CNT_W'(1) << dec.size_log2;
            s_d.crc  = crc_init;
            s_d.msg  = msg_in;
            s_d.poly = dec.poly;
            s_d.rd   = dec.acc_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = s_q.busy;
    assign fold_crc  = s_q.crc;
    assign fold_byte = s_q.msg[BYTE_W-1:0];
    assign fold_poly = s_q.poly;
    assign done      = s_q.done;
    assign wen       = s_q.wen;
    assign rd        = s_q.rd;
    assign data      = s_q.data;

    // R9
    left_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> (s_q.left != '0) && (s_q.left <= CNT_W'(MAX_BYTES)));
    // R9
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> !$past(s_q.done && !s_q.busy) || !s_q.busy);
    // R10
    busy_holds_poly_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && $past(s_q.busy)) |-> $stable(s_q.poly) && $stable(s_q.rd));

endmodule

// File: rtl/crc_accum_exu.sv
module crc_accum_exu
    import crc_accum_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [INSN_W-1:0]   insn,
    input  logic [XLEN-1:0]     rs_val,
    input  logic [CRC_W-1:0]    rt_lo,
    input  logic                feat_en,
    input  logic                mode64,
    output logic [IDX_W-1:0]    rs_idx,
    output logic                out_rsvd,
    output logic                out_done,
    output logic                out_wen,
    output logic [IDX_W-1:0]    out_rd,
    output logic [XLEN-1:0]     out_data
);

    dec_t             dec;
    logic             busy;
    logic             accept;
    logic             start;
    logic [CRC_W-1:0] fold_crc;
    logic [CRC_W-1:0] fold_res;
    logic [BYTE_W-1:0] fold_byte;
    poly_sel_e        fold_poly;

    crc_insn_decode i_decode (
        .insn    (insn),
        .feat_en (feat_en),
        .mode64  (mode64),
        .dec     (dec)
    );

    crc_byte_fold #(.STEPS(BYTE_W)) i_fold (
        .crc_in   (fold_crc),
        .msg_byte (fold_byte),
        .poly     (fold_poly),
        .crc_out  (fold_res)
    );

    crc_fold_seq #(.XLEN(XLEN)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dec       (dec),
        .msg_in    (rs_val),
        .crc_init  (rt_lo),
        .busy      (busy),
        .fold_crc  (fold_crc),
        .fold_byte (fold_byte),
        .fold_poly (fold_poly),
        .fold_res  (fold_res),
        .done      (out_done),
        .wen       (out_wen),
        .rd        (out_rd),
        .data      (out_data)
    );

    always_comb begin
        in_ready = !busy;
        accept   = in_valid && in_ready;
        start    = accept && !dec.illegal;
        out_rsvd = accept && dec.illegal;
        rs_idx   = dec.src_idx;
    end

    // R8
    rsvd_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_rsvd && !$past(start)) |=> !out_done);
    // R8
    rsvd_in_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_rsvd |-> in_valid && in_ready);
    // R9
    busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !in_ready);
    // R7
    wen_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_wen |-> out_done && (out_rd != '0));
    // R6
    sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> (out_data[XLEN-1:CRC_W] == {(XLEN-CRC_W){out_data[CRC_W-1]}}));

endmodule

// File: tb/test_crc_accum_exu.sv
module test_crc_accum_exu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] insn = '0;
    logic [63:0] rs_val = '0;
    logic [31:0] rt_lo = '0;
    logic        feat_en = 1'b1;
    logic        mode64 = 1'b1;
    logic [4:0]  rs_idx;
    logic        out_rsvd;
    logic        out_done;
    logic        out_wen;
    logic [4:0]  out_rd;
    logic [63:0] out_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    crc_accum_exu i_crc_accum_exu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .insn(insn), .rs_val(rs_val), .rt_lo(rt_lo), .feat_en(feat_en),
        .mode64(mode64), .rs_idx(rs_idx), .out_rsvd(out_rsvd),
        .out_done(out_done), .out_wen(out_wen), .out_rd(out_rd),
        .out_data(out_data)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [4:0] rs, input logic [4:0] rt,
                                       input logic [2:0] c, input logic [1:0] sz);
        return {6'b011111, rs, rt, 5'b00000, c, sz, 6'b001111};
    endfunction

    function automatic logic [63:0] ref_crc(input logic [31:0] crc0, input logic [63:0] msg,
                                            input int nbytes, input logic c);
        logic [31:0] poly = c ? 32'h82F63B78 : 32'hEDB88320;
        logic [31:0] crc = crc0;
        for (int b = 0; b < nbytes; b++) begin
            crc = crc ^ {24'h0, msg[8*b +: 8]};
            for (int k = 0; k < 8; k++)
                crc = crc[0] ? ((crc >> 1) ^ poly) : (crc >> 1);
        end
        return {{32{crc[31]}}, crc};
    endfunction

    // Offers one instruction and follows it to completion or refusal.
    task automatic run_op(input string req, input logic [31:0] w, input logic [63:0] rs,
                          input logic [31:0] rt, input logic fe, input logic m64,
                          input bit exp_rsvd, input bit hold_busy);
        int nb = 1 << w[7:6];
        logic [63:0] exp = ref_crc(rt, rs, nb, w[8]);
        @(negedge clk);
        in_valid = 1'b1; insn = w; rs_val = rs; rt_lo = rt; feat_en = fe; mode64 = m64;
        #1;
        check({req, " ready before accept (R9)"}, in_ready, 1'b1);
        check({req, " rsvd flag (R8)"}, out_rsvd, exp_rsvd);
        check({req, " rs index (R1)"}, rs_idx, w[25:21]);
        @(posedge clk);
        if (exp_rsvd) begin
            @(negedge clk);
            in_valid = 1'b0;
            #1;
            check({req, " no done after rsvd (R8)"}, out_done, 1'b0);
            check({req, " ready after rsvd (R8)"}, in_ready, 1'b1);
            return;
        end
        for (int j = 1; j <= nb; j++) begin
            @(negedge clk);
            if (hold_busy && j < nb) begin
                in_valid = 1'b1; insn = mk(5'd3, 5'd9, 3'd1, 2'd0);
                rs_val = ~rs; rt_lo = ~rt;
            end else begin
                in_valid = 1'b0;
            end
            #1;
            check({req, " busy ready low (R9)"}, in_ready, 1'b0);
            check({req, " done not early (R9)"}, out_done, 1'b0);
            if (hold_busy && j < nb)
                check({req, " no rsvd while busy (R10)"}, out_rsvd, 1'b0);
        end
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        check({req, " done on time (R9)"}, out_done, 1'b1);
        check({req, " result (R5 R6)"}, out_data, exp);
        check({req, " dest (R7)"}, out_rd, w[20:16]);
        check({req, " wen (R7)"}, out_wen, w[20:16] != 5'd0);
        check({req, " ready at done (R9)"}, in_ready, 1'b1);
        @(negedge clk);
        #1;
        check({req, " done one cycle (R9)"}, out_done, 1'b0);
    endtask

    task automatic t_reset();
        check("R9 reset ready", in_ready, 1'b1);
        check("R9 reset done", out_done, 1'b0);
        check("R7 reset wen", out_wen, 1'b0);
        check("R8 reset rsvd", out_rsvd, 1'b0);
    endtask

    task automatic t_known_vector();
        run_op("R3 crc32 one byte", mk(5'd4, 5'd5, 3'd0, 2'd0), 64'h0, 32'hFFFFFFFF, 1, 1, 0, 0);
        check("R3 crc32 FFFFFFFF/00 constant", out_data, 64'h000000002DFD1072);
    endtask

    task automatic t_sizes();
        run_op("R5 two bytes masked", mk(5'd1, 5'd2, 3'd0, 2'd1), 64'hDEADBEEF_CAFE1234, 32'h12345678, 1, 1, 0, 0);
        run_op("R5 four bytes masked", mk(5'd6, 5'd7, 3'd1, 2'd2), 64'hFFFFFFFF_A5A55A5A, 32'h00000000, 1, 0, 0, 0);
        run_op("R4 eight bytes crc32c", mk(5'd8, 5'd10, 3'd1, 2'd3), 64'h01234567_89ABCDEF, 32'hFFFFFFFF, 1, 1, 0, 0);
        run_op("R6 eight bytes crc32", mk(5'd11, 5'd12, 3'd0, 2'd3), 64'h80000000_00000001, 32'h80000000, 1, 1, 0, 0);
    endtask

    task automatic t_zero_dest();
        run_op("R7 zero dest", mk(5'd3, 5'd0, 3'd0, 2'd2), 64'h11223344, 32'hCAFEBABE, 1, 1, 0, 0);
    endtask

    task automatic t_reserved();
        run_op("R2 feature off", mk(5'd1, 5'd2, 3'd0, 2'd0), 64'h5, 32'h1, 0, 1, 1, 0);
        run_op("R3 poly code 2", mk(5'd1, 5'd2, 3'd2, 2'd0), 64'h5, 32'h1, 1, 1, 1, 0);
        run_op("R3 poly code 7", mk(5'd1, 5'd2, 3'd7, 2'd1), 64'h5, 32'h1, 1, 1, 1, 0);
        run_op("R4 size 3 no mode64", mk(5'd1, 5'd2, 3'd0, 2'd3), 64'h5, 32'h1, 1, 0, 1, 0);
        run_op("R1 bad major op", mk(5'd1, 5'd2, 3'd0, 2'd0) ^ 32'h0400_0000, 64'h5, 32'h1, 1, 1, 1, 0);
        run_op("R1 nonzero bits 15:11", mk(5'd1, 5'd2, 3'd0, 2'd0) | 32'h0000_0800, 64'h5, 32'h1, 1, 1, 1, 0);
        run_op("R1 bad minor op", mk(5'd1, 5'd2, 3'd0, 2'd0) ^ 32'h0000_0001, 64'h5, 32'h1, 1, 1, 1, 0);
    endtask

    task automatic t_busy_inputs();
        run_op("R10 junk while busy", mk(5'd13, 5'd14, 3'd0, 2'd3), 64'hFEDCBA98_76543210, 32'h0BADF00D, 1, 1, 0, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_known_vector();
        t_sizes();
        t_zero_dest();
        t_reserved();
        t_busy_inputs();
        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog run did not finish actual=0 expected=1");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule